// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Reset-Selected Write Enables

This block is a first-in first-out buffer, nine bits wide, whose write side runs on one clock and whose read side runs on a second clock. The two clocks may be tied together or be fully unrelated. Each side keeps a binary pointer and passes a Gray-coded copy of it to the other side through a two-stage synchronizer. Both sides therefore see the far pointer a few cycles late, so their flags are pessimistic but never wrong. The write side drives active-low full and almost-full flags. The read side drives active-low empty and almost-empty flags, a registered data word, and a tri-state data bus gated by an active-low output enable.

The level of the dual-purpose write control, sampled while reset is held, picks the write-enable scheme. If it is high, writes need both enables. If it is low, the block is in offset-load mode: enable 1 alone controls writes, and any write-clock edge where the load line is low goes to an external offset loader, which this block flags on `ofs_wr_slot`. The almost thresholds come in on input ports from that loader. It sets them to 7 when it is reset.

Top module: `dcfifo9`

## Requirements
- R1: While `rst` is high at a write-clock edge, the write pointer returns to location 0 and `full_n` and `afull_n` go high. While `rst` is high at a read-clock edge, the read pointer returns to location 0 and `empty_n` and `aempty_n` go low.
- R2: Reset clears the output data register to 0, so with `oe_n` low `dout` reads 9'h000 after reset.
- R3: The level of `wen2_ld` during reset sets the mode. If it is high (dual-enable mode), a write needs `wen1_n` low and `wen2_ld` high, and `ofs_wr_slot` stays low. If it is low (offset-load mode), an edge with `wen1_n` low and `wen2_ld` high writes, and an edge with both low does not write and raises `ofs_wr_slot`.
- R4: A read-clock edge with `rd_en1_n` and `rd_en2_n` both low loads the oldest word into the output register. If either enable is high, the output register holds its value.
- R5: Writes are ignored while `full_n` is low, and reads are ignored while `empty_n` is low. No word is lost, duplicated or reordered.
- R6: Words come out in the order they were written, with their values intact, when the two clocks run at different rates.
- R7: `aempty_n` is updated on the read clock and is low when the read-side fill level is at or below `ae_ofs`.
- R8: `afull_n` is updated on the write clock and is low when the write-side fill level is at or above DEPTH minus `af_ofs`. With no reads, it falls on the write edge that stores word DEPTH-`af_ofs`.
- R9: `dout` is high impedance while `oe_n` is high and shows the output register while `oe_n` is low.
- R10: `full_n` falls on the write edge that stores word DEPTH. `empty_n` rises within a few read clocks after a write and falls when the last word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across several edges of both clocks |
| din | input | 9 | Write data |
| wen1_n | input | 1 | Write enable 1, active low |
| wen2_ld | input | 1 | Write enable 2 in dual-enable mode; load select in offset-load mode |
| rd_en1_n | input | 1 | Read enable 1, active low |
| rd_en2_n | input | 1 | Read enable 2, active low |
| oe_n | input | 1 | Output enable, active low |
| ae_ofs | input | 10 | Almost-empty threshold from the offset loader |
| af_ofs | input | 10 | Almost-full distance from the offset loader |
| dout | output | 9 | Read data, tri-state |
| empty_n | output | 1 | Empty flag, low when empty (read clock) |
| aempty_n | output | 1 | Almost-empty flag, active low (read clock) |
| full_n | output | 1 | Full flag, low when full (write clock) |
| afull_n | output | 1 | Almost-full flag, active low (write clock) |
| ofs_wr_slot | output | 1 | High when the current write edge belongs to the offset loader |

## Verification
If a pointer goes wrong, the read port shows it directly. The scoreboard sees a word that is skipped, repeated or out of order on the first read that reaches the bad location. A wrong threshold or flag update shows up as a flag edge that comes one word early or late. The bench therefore checks the almost-full and full flags on the exact write edge where they should change, while no reads run. A wrongly captured mode shows on `ofs_wr_slot` as soon as load is driven low, and afterwards as a word that should not be in the buffer.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    localparam int DW = 9;
    localparam int OFS_DEFAULT = 7;

    typedef enum logic {
        MODE_DUAL_WE   = 1'b0,
        MODE_OFS_LOAD  = 1'b1
    } wr_mode_e;

    typedef struct packed {
        logic full_n;
        logic afull_n;
    } wr_flags_t;

    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rd_flags_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction
endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
    parameter int DEPTH = 1024,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [PW-1:0] rgray_s,
    input  logic [AW-1:0] af_ofs,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [PW-1:0] wgray,
    output wr_flags_t     flags,
    output logic          ofs_wr_slot
);
    wr_mode_e      mode_q;
    logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_s, lvl_nx, af_lim;
    logic          wr_do;

    assign ofs_wr_slot = !rst && (mode_q == MODE_OFS_LOAD) && !wen1_n && !wen2_ld;
    assign wr_do       = !rst && flags.full_n && !wen1_n && wen2_ld;
    assign wbin_nx     = wbin + PW'(wr_do);
    assign wgray_nx    = PW'(bin2gray(32'(wbin_nx)));
    assign rbin_s      = PW'(gray2bin(32'(rgray_s)));
    assign lvl_nx      = wbin_nx - rbin_s;
    assign af_lim      = PW'(DEPTH) - {1'b0, af_ofs};
    assign mem_we      = wr_do;
    assign mem_waddr   = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q        <= wen2_ld ? MODE_DUAL_WE : MODE_OFS_LOAD;
            wbin          <= '0;
            wgray         <= '0;
            flags.full_n  <= 1'b1;
            flags.afull_n <= 1'b1;
        end else begin
            wbin          <= wbin_nx;
            wgray         <= wgray_nx;
            flags.full_n  <= wgray_nx != {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
            flags.afull_n <= lvl_nx < af_lim;
        end
    end

    // R1
    wr_reset_state_chk: assert property (@(posedge clk)
        rst |=> (flags.full_n && flags.afull_n && wbin == '0));
    // R5
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        !flags.full_n |=> $stable(wbin));
    // R3
    load_slot_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        ofs_wr_slot |=> $stable(wbin));
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] ae_ofs,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] q,
    output rd_flags_t     flags
);
    logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s, lvl_nx;
    logic          rd_do;

    assign rd_do     = flags.empty_n && !ren1_n && !ren2_n;
    assign rbin_nx   = rbin + PW'(rd_do);
    assign rgray_nx  = PW'(bin2gray(32'(rbin_nx)));
    assign wbin_s    = PW'(gray2bin(32'(wgray_s)));
    assign lvl_nx    = wbin_s - rbin_nx;
    assign mem_raddr = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin           <= '0;
            rgray          <= '0;
            q              <= '0;
            flags.empty_n  <= 1'b0;
            flags.aempty_n <= 1'b0;
        end else begin
            rbin           <= rbin_nx;
            rgray          <= rgray_nx;
            if (rd_do) q   <= mem_rdata;
            flags.empty_n  <= rgray_nx != wgray_s;
            flags.aempty_n <= lvl_nx > {1'b0, ae_ofs};
        end
    end

    // R5
    no_read_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !flags.empty_n |=> ($stable(rbin) && $stable(q)));
    // R4
    hold_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (ren1_n || ren2_n) |=> $stable(q));
    // R1
    rd_reset_state_chk: assert property (@(posedge clk)
        rst |=> (!flags.empty_n && !flags.aempty_n && rbin == '0 && q == '0));
endmodule

// File: rtl/dcfifo9.sv
module dcfifo9
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic          rd_en1_n,
    input  logic          rd_en2_n,
    input  logic          oe_n,
    input  logic [AW-1:0] ae_ofs,
    input  logic [AW-1:0] af_ofs,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          full_n,
    output logic          afull_n,
    output logic          ofs_wr_slot
);
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_rdata, q;
    wr_flags_t     wflags;
    rd_flags_t     rflags;

    dcfifo_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk(wclk), .rst(rst), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
        .rgray_s(rgray_s), .af_ofs(af_ofs), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .wgray(wgray), .flags(wflags),
        .ofs_wr_slot(ofs_wr_slot)
    );

    dcfifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk(rclk), .rst(rst), .ren1_n(rd_en1_n), .ren2_n(rd_en2_n),
        .wgray_s(wgray_s), .ae_ofs(ae_ofs), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .rgray(rgray), .q(q), .flags(rflags)
    );

    dcfifo_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
    dcfifo_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));

    dcfifo_ram #(.DEPTH(DEPTH), .W(DW)) u_ram (
        .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    assign full_n   = wflags.full_n;
    assign afull_n  = wflags.afull_n;
    assign empty_n  = rflags.empty_n;
    assign aempty_n = rflags.aempty_n;
    assign dout     = oe_n ? {DW{1'bz}} : q;
endmodule

// File: tb/tb_dcfifo9.sv
module tb_dcfifo9;
    localparam int DEPTH = 1024;

    logic       wclk = 0, rclk = 0, rst = 1;
    logic [8:0] din = '0;
    logic       wen1_n = 1, wen2_ld = 1, rd_en1_n = 1, rd_en2_n = 1, oe_n = 0;
    logic [9:0] ae_ofs = 10'd7, af_ofs = 10'd7;
    logic [8:0] dout;
    logic       empty_n, aempty_n, full_n, afull_n, ofs_wr_slot;

    int total = 0, bad = 0;
    bit done = 0;
    logic [8:0] sb[$];
    logic [8:0] last_rd = '0;

    dcfifo9 #(.DEPTH(DEPTH)) dut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .din(din), .wen1_n(wen1_n),
        .wen2_ld(wen2_ld), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
        .oe_n(oe_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(dout),
        .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n),
        .afull_n(afull_n), .ofs_wr_slot(ofs_wr_slot)
    );

    always #4 wclk = ~wclk;
    always #5 rclk = ~rclk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode_lvl);
        @(negedge wclk);
        rst = 1; wen2_ld = mode_lvl; wen1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
        repeat (6) @(negedge rclk);
        rst = 0;
        @(negedge wclk); wen2_ld = 1;
        repeat (2) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
    endtask

    // driver: one write attempt; pushes expected word if the edge will accept it
    task automatic put(input logic [8:0] d);
        @(negedge wclk);
        din = d; wen1_n = 0; wen2_ld = 1;
        if (full_n) sb.push_back(d);
        @(negedge wclk);
        wen1_n = 1;
    endtask

    task automatic put_burst(input int n, input logic [8:0] seed);
        @(negedge wclk);
        for (int i = 0; i < n; i++) begin
            din = seed + 9'(i * 37); wen1_n = 0; wen2_ld = 1;
            if (full_n) sb.push_back(din);
            @(negedge wclk);
        end
        wen1_n = 1;
    endtask

    // monitor: reads while not empty, pops and compares each produced word
    task automatic drain(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge rclk);
            if (empty_n) begin
                rd_en1_n = 0; rd_en2_n = 0;
                @(negedge rclk);
                rd_en1_n = 1; rd_en2_n = 1;
                if (sb.size() == 0) begin
                    check(0, "R5 extra word", {23'd0, dout}, 0);
                end else begin
                    logic [8:0] e = sb.pop_front();
                    check(dout === e, "R6 order/data", {23'd0, dout}, {23'd0, e});
                    last_rd = e;
                end
                got++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // ---- dual-enable mode ----
        do_reset(1'b1);
        check(empty_n == 0 && aempty_n == 0, "R1 read flags", {empty_n, aempty_n}, 0);
        check(full_n == 1 && afull_n == 1, "R1 write flags", {full_n, afull_n}, 3);
        check(dout === 9'h000, "R2 output reg zero", {23'd0, dout}, 0);
        oe_n = 1; #1;
        check(dout === 9'hzzz, "R9 high-z", {23'd0, dout}, 0);
        oe_n = 0;

        // R3: second enable low blocks writes in dual mode, no load slot
        @(negedge wclk); din = 9'h1AA; wen1_n = 0; wen2_ld = 0;
        @(negedge wclk);
        check(ofs_wr_slot == 0, "R3 no slot in dual mode", {31'd0, ofs_wr_slot}, 0);
        @(negedge wclk); wen1_n = 1; wen2_ld = 1;
        settle();
        check(empty_n == 0, "R3 blocked write", {31'd0, empty_n}, 0);

        put_burst(7, 9'h011);
        settle();
        check(empty_n == 1, "R10 not empty", {31'd0, empty_n}, 1);
        check(aempty_n == 0, "R7 level 7 <= 7", {31'd0, aempty_n}, 0);
        put(9'h155);
        settle();
        check(aempty_n == 1, "R7 level 8 > 7", {31'd0, aempty_n}, 1);

        drain(1);
        // R4: one enable high, output holds
        @(negedge rclk); rd_en1_n = 0; rd_en2_n = 1;
        repeat (3) @(negedge rclk);
        check(dout === last_rd, "R4 hold with one enable high", {23'd0, dout}, {23'd0, last_rd});
        @(negedge rclk); rd_en1_n = 1; rd_en2_n = 0;
        repeat (3) @(negedge rclk);
        check(dout === last_rd, "R4 hold with other enable high", {23'd0, dout}, {23'd0, last_rd});
        rd_en2_n = 1;
        drain(7);
        settle();
        check(empty_n == 0, "R10 empty after last read", {31'd0, empty_n}, 0);
        // R5: reads on empty ignored
        @(negedge rclk); rd_en1_n = 0; rd_en2_n = 0;
        repeat (4) @(negedge rclk);
        rd_en1_n = 1; rd_en2_n = 1;
        check(dout === last_rd, "R5 read on empty ignored", {23'd0, dout}, {23'd0, last_rd});

        // ---- fill to full, exact flag edges (R8, R10) ----
        do_reset(1'b1);
        sb.delete();
        put_burst(DEPTH - 8, 9'h003);
        check(afull_n == 1, "R8 below threshold", {31'd0, afull_n}, 1);
        put(9'h0F0);
        check(afull_n == 0, "R8 at DEPTH-7", {31'd0, afull_n}, 0);
        check(full_n == 1, "R10 not yet full", {31'd0, full_n}, 1);
        put_burst(6, 9'h100);
        check(full_n == 1, "R10 one slot left", {31'd0, full_n}, 1);
        put(9'h0AB);
        check(full_n == 0, "R10 full at DEPTH", {31'd0, full_n}, 0);
        put(9'h1FF); put(9'h1FE); put(9'h1FD);
        check(sb.size() == DEPTH, "R5 writes on full ignored", sb.size(), DEPTH);
        settle();
        drain(DEPTH);
        settle();
        check(full_n == 1 && afull_n == 1, "R10 flags recover", {full_n, afull_n}, 3);
        check(empty_n == 0, "R5 nothing extra stored", {31'd0, empty_n}, 0);

        // ---- offset-load mode ----
        do_reset(1'b0);
        sb.delete();
        @(negedge wclk); din = 9'h0C3; wen1_n = 0; wen2_ld = 0;
        #1;
        check(ofs_wr_slot == 1, "R3 load slot raised", {31'd0, ofs_wr_slot}, 1);
        repeat (2) @(negedge wclk);
        wen1_n = 1; wen2_ld = 1;
        settle();
        check(empty_n == 0, "R3 load edges not written", {31'd0, empty_n}, 0);
        ae_ofs = 10'd2; af_ofs = 10'd1020;
        put_burst(2, 9'h020);
        settle();
        check(aempty_n == 0, "R7 programmed threshold 2", {31'd0, aempty_n}, 0);
        put(9'h0E1);
        settle();
        check(aempty_n == 1, "R7 level 3 > 2", {31'd0, aempty_n}, 1);
        check(afull_n == 1, "R8 level 3 below 4", {31'd0, afull_n}, 1);
        put(9'h0E2);
        check(afull_n == 0, "R8 programmed distance", {31'd0, afull_n}, 0);
        check(ofs_wr_slot == 0, "R3 enable-1 write not a slot", {31'd0, ofs_wr_slot}, 0);
        settle();
        drain(4);
        check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule